// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block holds the configuration of one group of general-purpose pads and connects that configuration to the pads. A 32-bit register port on a simple bus reaches three kinds of storage. The first is a read-only pointer that tells software where the per-pad words begin. The second is a miscellaneous configuration word. The third is a set of ownership words, each with a 2-bit owner field for every pad. At the location the pointer names, each pad has two consecutive words. Word 0 holds the direction controls, the pad-function field, the drive value, a force-high control for the receive path and a read-only copy of the sampled pad level. Word 1 holds termination and standby settings. The block only stores these and exports the termination code.

On the pad side, each pad gets an output enable and an output value. Each pad's receiver input is synchronised before software can see it. A pad whose function field is nonzero belongs to another function, so this block neither drives it nor lets host writes change its output value. A pad whose owner code is nonzero is also protected from host output-value writes. Software reads back the configuration as stored. Bit 1 of word 0 shows the received level, and bit 0 shows the value to drive.

Top module: `gpio_padcfg_bank`

## Requirements
- R1: After a synchronous active-low reset, every pad is an input: word 0 reads 0x0000_0100 with the pad input low (transmit disabled at bit 8, receiver enabled at bit 9 clear, output value bit 0 clear, function field zero), word 1 reads 0, `pad_oe`, `pad_out` and `pad_term` are all 0, and every owner field is 0.
- R2: Offset 0x00C reads the parameter `PAD_BASE`, and writes to it have no effect.
- R3: Pad n's word 0 is at `PAD_BASE + 8*n` and its word 1 is at `PAD_BASE + 8*n + 4`. A write to one pad's word changes no other pad.
- R4: `pad_oe[n]` is 1 exactly when word 0 bit 8 is 0 and the function field (word 0 bits 13:10) is 0. `pad_out[n]` equals word 0 bit 0 while `pad_oe[n]` is 1 and is 0 otherwise.
- R5: Word 0 bit 1 reads the pad input after `SYNC_STAGES` clock edges. It reads 0 while bit 9 (receive disable) is set, and reads 1 while bit 28 (force high) is set and the receiver is enabled. Writes to bit 1 have no effect.
- R6: While the stored function field is nonzero, the pad is not driven. A host write to that pad's word 0 leaves bit 0 unchanged, while its other fields still take the written value. The check uses the field value held before the write.
- R7: Owner words sit at 0x020 + 4*k, one per 8 pads. Pad n's owner field is bits [2*(n%8)+1 : 2*(n%8)] of word n/8. While a pad's owner code is nonzero, host writes leave its word 0 bit 0 unchanged.
- R8: Word 1 stores standby termination at bits 9:8, termination at bits 13:10 (0x0 none, 0x4 pull-down, 0xC pull-up) and standby state at bits 17:14. All other bits read 0. `pad_term[4n+3:4n]` follows bits 13:10.
- R9: Writes to undefined or misaligned offsets are dropped, and reads of them return 0.
- R10: `bus_rdata` is loaded on the clock edge that samples `bus_rd_en` and holds its value until the next read.
- R11: Offset 0x010 is a 32-bit read/write miscellaneous register that resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_rd_en | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | NUM_PADS | Receiver level from each pad |
| pad_oe | output | NUM_PADS | Output-buffer enable per pad |
| pad_out | output | NUM_PADS | Value driven per pad |
| pad_term | output | 4*NUM_PADS | Stored termination code per pad |
| pad_mode | output | 4*NUM_PADS | Stored function field per pad |

## Verification
A wrong direction or function bit appears on `pad_oe` in the cycle after the write that set it. A wrong output-value bit appears on `pad_out` in that same cycle whenever the pad is driving. When the pad is not driving, that bit is hidden until a read of word 0. A fault in the input path shows only in bit 1 of a word-0 read, `SYNC_STAGES` edges after the pad changes. Decode faults show up as a changed word at an unexpected address, or as nonzero data from a hole. The tests therefore read back a neighbouring pad or the hole after every targeted write.

// File: rtl/gpio_padcfg_pkg.sv
`timescale 1ns/1ps
// Shared offsets, field positions and decode kinds for the pad bank.
// Assumes 32-bit word-aligned byte addressing.
package gpio_padcfg_pkg;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_BASE,
        RK_MISC,
        RK_OWNER,
        RK_CFG0,
        RK_CFG1
    } reg_kind_e;

    localparam int unsigned OFS_BASE_PTR   = 32'h00C;
    localparam int unsigned OFS_MISC       = 32'h010;
    localparam int unsigned OFS_OWNER      = 32'h020;
    localparam int unsigned PADS_PER_OWNER = 8;
    localparam int unsigned OWNER_FIELD_W  = 2;

    // word 0 bit positions
    localparam int C0_TXVAL   = 0;
    localparam int C0_RXSTATE = 1;
    localparam int C0_TXDIS   = 8;
    localparam int C0_RXDIS   = 9;
    localparam int C0_MODE_LO = 10;
    localparam int C0_FORCE1  = 28;

    // word 1 bit positions
    localparam int C1_SBTERM_LO  = 8;
    localparam int C1_TERM_LO    = 10;
    localparam int C1_SBSTATE_LO = 14;

endpackage

// File: rtl/gpio_padcfg_decode.sv
`timescale 1ns/1ps
// Address decoder: maps a byte address to a register kind and an index.
// The index is a pad number for per-pad words and a word number for owner
// words. Assumes PAD_BASE is 8-byte aligned and lies above the owner region.
module gpio_padcfg_decode
    import gpio_padcfg_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_PADS  = 16,
    parameter int PAD_BASE  = 'h400,
    parameter int IDX_W     = 4,
    parameter int OWN_WORDS = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);

    localparam int unsigned OWN_END = OFS_OWNER + 4 * OWN_WORDS;
    localparam int unsigned PAD_END = PAD_BASE + 8 * NUM_PADS;

    // Classify the address; misaligned and unlisted addresses map to RK_NONE.
    always_comb begin
        int unsigned a;
        int unsigned off;
        a    = 32'(addr);
        off  = 0;
        kind = RK_NONE;
        idx  = '0;
        if (addr[1:0] == 2'b00) begin
            if (a == OFS_BASE_PTR) begin
                kind = RK_BASE;
            end else if (a == OFS_MISC) begin
                kind = RK_MISC;
            end else if (a >= OFS_OWNER && a < OWN_END) begin
                kind = RK_OWNER;
                idx  = IDX_W'((a - OFS_OWNER) >> 2);
            end else if (a >= 32'(PAD_BASE) && a < PAD_END) begin
                off  = a - 32'(PAD_BASE);
                kind = ((off & 32'd4) != 0) ? RK_CFG1 : RK_CFG0;
                idx  = IDX_W'(off >> 3);
            end
        end
    end

endmodule

// File: rtl/gpio_padcfg_owner.sv
`timescale 1ns/1ps
// Ownership fields: a 2-bit code per pad, packed 8 pads per 32-bit word.
// Code 0 means the host owns the pad. Assumes idx has already been checked
// by the decoder to be below OWN_WORDS.
module gpio_padcfg_owner
    import gpio_padcfg_pkg::*;
#(
    parameter int NUM_PADS  = 16,
    parameter int IDX_W     = 4,
    parameter int OWN_WORDS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IDX_W-1:0]      idx,
    input  logic [31:0]           wdata,
    output logic [31:0]           rd_word,
    output logic [2*NUM_PADS-1:0] owner_codes
);

    logic [1:0] own_q [NUM_PADS];

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_own
        localparam int WORD = p / PADS_PER_OWNER;
        localparam int SLOT = p % PADS_PER_OWNER;
        // Store this pad's owner field when its word is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                own_q[p] <= 2'b00;
            end else if (we && int'(idx) == WORD) begin
                own_q[p] <= wdata[OWNER_FIELD_W*SLOT +: OWNER_FIELD_W];
            end
        end
        assign owner_codes[2*p +: 2] = own_q[p];
    end

    // Assemble the selected owner word from the pads it covers.
    always_comb begin
        rd_word = '0;
        for (int s = 0; s < PADS_PER_OWNER; s++) begin
            int p;
            p = int'(idx) * PADS_PER_OWNER + s;
            if (p < NUM_PADS) begin
                rd_word[OWNER_FIELD_W*s +: OWNER_FIELD_W] = own_q[p];
            end
        end
    end

endmodule

// File: rtl/gpio_padcfg_pad.sv
`timescale 1ns/1ps
// One pad: stores both configuration words, drives the output buffer and
// synchronises the receiver level. Assumes pad_in is asynchronous to clk.
// The output-value guard uses the function field and owner code held
// before the write.
module gpio_padcfg_pad
    import gpio_padcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg0_we,
    input  logic        cfg1_we,
    input  logic [31:0] wdata,
    input  logic [1:0]  owner_code,
    input  logic        pad_in,
    output logic [31:0] cfg0_rd,
    output logic [31:0] cfg1_rd,
    output logic        pad_oe,
    output logic        pad_out,
    output logic [3:0]  term,
    output logic [3:0]  mode
);

    logic                   tx_val_q, tx_dis_q, rx_dis_q, force_hi_q;
    logic [3:0]             mode_q, term_q, sb_state_q;
    logic [1:0]             sb_term_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   host_may_drive, gpio_sel, rx_state;

    assign gpio_sel       = (mode_q == 4'h0);
    assign host_may_drive = gpio_sel && (owner_code == 2'b00);

    // Word 0 storage; bit 0 is written only when the host controls the pad.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_val_q   <= 1'b0;
            tx_dis_q   <= 1'b1;
            rx_dis_q   <= 1'b0;
            mode_q     <= 4'h0;
            force_hi_q <= 1'b0;
        end else if (cfg0_we) begin
            tx_dis_q   <= wdata[C0_TXDIS];
            rx_dis_q   <= wdata[C0_RXDIS];
            mode_q     <= wdata[C0_MODE_LO +: 4];
            force_hi_q <= wdata[C0_FORCE1];
            if (host_may_drive) tx_val_q <= wdata[C0_TXVAL];
        end
    end

    // Word 1 storage: termination and standby fields only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sb_term_q  <= 2'b00;
            term_q     <= 4'h0;
            sb_state_q <= 4'h0;
        end else if (cfg1_we) begin
            sb_term_q  <= wdata[C1_SBTERM_LO +: 2];
            term_q     <= wdata[C1_TERM_LO +: 4];
            sb_state_q <= wdata[C1_SBSTATE_LO +: 4];
        end
    end

    // Synchroniser chain for the receiver level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= (sync_q << 1) | SYNC_STAGES'(pad_in);
    end

    assign rx_state = !rx_dis_q && (force_hi_q || sync_q[SYNC_STAGES-1]);
    assign pad_oe   = gpio_sel && !tx_dis_q;
    assign pad_out  = pad_oe && tx_val_q;
    assign term     = term_q;
    assign mode     = mode_q;

    // Read-back images of both words.
    always_comb begin
        cfg0_rd = '0;
        cfg0_rd[C0_TXVAL]       = tx_val_q;
        cfg0_rd[C0_RXSTATE]     = rx_state;
        cfg0_rd[C0_TXDIS]       = tx_dis_q;
        cfg0_rd[C0_RXDIS]       = rx_dis_q;
        cfg0_rd[C0_MODE_LO +: 4] = mode_q;
        cfg0_rd[C0_FORCE1]      = force_hi_q;
        cfg1_rd = '0;
        cfg1_rd[C1_SBTERM_LO +: 2]  = sb_term_q;
        cfg1_rd[C1_TERM_LO +: 4]    = term_q;
        cfg1_rd[C1_SBSTATE_LO +: 4] = sb_state_q;
    end

endmodule

// File: rtl/gpio_padcfg_bank.sv
`timescale 1ns/1ps
// Top of the pad configuration bank: decode, pointer and misc registers,
// owner words and one slice per pad, with a registered read port.
// Assumes single-cycle strobes with address and data valid alongside them.
module gpio_padcfg_bank
    import gpio_padcfg_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int NUM_PADS    = 16,
    parameter int PAD_BASE    = 'h400,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr_en,
    input  logic                  bus_rd_en,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PADS-1:0]   pad_in,
    output logic [NUM_PADS-1:0]   pad_oe,
    output logic [NUM_PADS-1:0]   pad_out,
    output logic [4*NUM_PADS-1:0] pad_term,
    output logic [4*NUM_PADS-1:0] pad_mode
);

    localparam int OWN_WORDS = (NUM_PADS + PADS_PER_OWNER - 1) / PADS_PER_OWNER;
    localparam int IDX_W     = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;

    reg_kind_e             kind;
    logic [IDX_W-1:0]      idx;
    logic [31:0]           misc_q, owner_rd, rd_mux;
    logic [2*NUM_PADS-1:0] owner_codes;
    logic [31:0]           cfg0_rd [NUM_PADS];
    logic [31:0]           cfg1_rd [NUM_PADS];

    gpio_padcfg_decode #(
        .ADDR_W(ADDR_W), .NUM_PADS(NUM_PADS), .PAD_BASE(PAD_BASE),
        .IDX_W(IDX_W), .OWN_WORDS(OWN_WORDS)
    ) decode_i (
        .addr(bus_addr), .kind(kind), .idx(idx)
    );

    gpio_padcfg_owner #(
        .NUM_PADS(NUM_PADS), .IDX_W(IDX_W), .OWN_WORDS(OWN_WORDS)
    ) owner_i (
        .clk(clk), .rst_n(rst_n),
        .we(bus_wr_en && kind == RK_OWNER),
        .idx(idx), .wdata(bus_wdata),
        .rd_word(owner_rd), .owner_codes(owner_codes)
    );

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        gpio_padcfg_pad #(.SYNC_STAGES(SYNC_STAGES)) pad_i (
            .clk(clk), .rst_n(rst_n),
            .cfg0_we(bus_wr_en && kind == RK_CFG0 && int'(idx) == p),
            .cfg1_we(bus_wr_en && kind == RK_CFG1 && int'(idx) == p),
            .wdata(bus_wdata),
            .owner_code(owner_codes[2*p +: 2]),
            .pad_in(pad_in[p]),
            .cfg0_rd(cfg0_rd[p]), .cfg1_rd(cfg1_rd[p]),
            .pad_oe(pad_oe[p]), .pad_out(pad_out[p]),
            .term(pad_term[4*p +: 4]), .mode(pad_mode[4*p +: 4])
        );
    end

    // Miscellaneous configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n)                             misc_q <= '0;
        else if (bus_wr_en && kind == RK_MISC)  misc_q <= bus_wdata;
    end

    // Select the read source by register kind; holes read zero.
    always_comb begin
        rd_mux = '0;
        case (kind)
            RK_BASE:  rd_mux = 32'(PAD_BASE);
            RK_MISC:  rd_mux = misc_q;
            RK_OWNER: rd_mux = owner_rd;
            RK_CFG0:  if (int'(idx) < NUM_PADS) rd_mux = cfg0_rd[idx];
            RK_CFG1:  if (int'(idx) < NUM_PADS) rd_mux = cfg1_rd[idx];
            default:  rd_mux = '0;
        endcase
    end

    // Registered read data, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_rdata <= '0;
        else if (bus_rd_en) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/gpio_padcfg_bank_chk.sv
`timescale 1ns/1ps
// Checker for the pad bank's port-level rules, attached by bind.
// Observes ports only; assumes the reset is held for at least one edge.
module gpio_padcfg_bank_chk #(
    parameter int NUM_PADS = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_rd_en,
    input logic [31:0]           bus_rdata,
    input logic [NUM_PADS-1:0]   pad_oe,
    input logic [NUM_PADS-1:0]   pad_out,
    input logic [4*NUM_PADS-1:0] pad_term,
    input logic [4*NUM_PADS-1:0] pad_mode
);

    a_r1_reset_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pad_oe == '0 && pad_out == '0 && pad_term == '0));

    a_r4_out_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd_en) |-> $stable(bus_rdata));

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_mode
        a_r6_alt_mode_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_mode[4*p +: 4] != 4'h0) |-> !pad_oe[p]);
    end

endmodule

bind gpio_padcfg_bank gpio_padcfg_bank_chk #(.NUM_PADS(NUM_PADS)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_term(pad_term), .pad_mode(pad_mode)
);

// File: tb/gpio_padcfg_bank_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module gpio_padcfg_bank_tb_top;

    localparam int ADDR_W = 12;
    localparam int NPADS  = 16;
    localparam int PBASE  = 'h400;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr_en = 1'b0, bus_rd_en = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0, bus_rdata;
    logic [NPADS-1:0]  pad_in = '0, pad_oe, pad_out;
    logic [4*NPADS-1:0] pad_term, pad_mode;

    int  n_checks = 0, n_fail = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    gpio_padcfg_bank #(.ADDR_W(ADDR_W), .NUM_PADS(NPADS), .PAD_BASE(PBASE), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_term(pad_term), .pad_mode(pad_mode)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = ADDR_W'(addr);
        @(negedge clk);
        bus_rd_en = 1'b0;
        data = bus_rdata;
    endtask

    function automatic int w0(input int n); return PBASE + 8*n; endfunction
    function automatic int w1(input int n); return PBASE + 8*n + 4; endfunction

    task automatic t_reset();
        logic [31:0] d;
        check("R1 pad_oe", 64'(pad_oe), 0);
        check("R1 pad_out", 64'(pad_out), 0);
        check("R1 pad_term", 64'(pad_term), 0);
        rd(w0(0), d);  check("R1 pad0 word0", 64'(d), 64'h100);
        rd(w0(15), d); check("R1 pad15 word0", 64'(d), 64'h100);
        rd(w1(15), d); check("R1 pad15 word1", 64'(d), 0);
        rd('h020, d);  check("R1 owner word", 64'(d), 0);
        rd('h010, d);  check("R11 misc reset", 64'(d), 0);
    endtask

    task automatic t_base_misc();
        logic [31:0] d;
        rd('h00C, d); check("R2 base pointer", 64'(d), 64'(PBASE));
        wr('h00C, 32'h123);
        rd('h00C, d); check("R2 base pointer write ignored", 64'(d), 64'(PBASE));
        wr('h010, 32'hA5A5_0003);
        rd('h010, d); check("R11 misc readback", 64'(d), 64'hA5A5_0003);
    endtask

    task automatic t_output();
        logic [31:0] d;
        wr(w0(3), 32'h201);
        check("R4 oe pad3 only", 64'(pad_oe), 64'h8);
        check("R4 out pad3", 64'(pad_out), 64'h8);
        rd(w0(3), d); check("R3 pad3 word0", 64'(d), 64'h201);
        rd(w0(4), d); check("R3 neighbour untouched", 64'(d), 64'h100);
        wr(w0(3), 32'h200);
        check("R4 out low", 64'(pad_out), 0);
        check("R4 oe kept", 64'(pad_oe), 64'h8);
        wr(w0(3), 32'h101);
        check("R4 tx disabled no oe", 64'(pad_oe), 0);
        check("R4 out masked", 64'(pad_out), 0);
        rd(w0(3), d); check("R4 stored value kept", 64'(d), 64'h101);
    endtask

    task automatic t_input();
        logic [31:0] d;
        @(negedge clk); pad_in[5] = 1'b1;
        repeat (3) @(negedge clk);
        rd(w0(5), d); check("R5 input high", 64'(d), 64'h102);
        @(negedge clk); pad_in[5] = 1'b0;
        repeat (3) @(negedge clk);
        rd(w0(5), d); check("R5 input low", 64'(d), 64'h100);
        wr(w0(5), 32'h1000_0100);
        rd(w0(5), d); check("R5 force high", 64'(d), 64'h1000_0102);
        @(negedge clk); pad_in[5] = 1'b1;
        wr(w0(5), 32'h300);
        repeat (3) @(negedge clk);
        rd(w0(5), d); check("R5 receiver disabled", 64'(d), 64'h300);
        @(negedge clk); pad_in[5] = 1'b0;
        wr(w0(5), 32'h102);
        repeat (3) @(negedge clk);
        rd(w0(5), d); check("R5 bit1 not writable", 64'(d), 64'h100);
    endtask

    task automatic t_mode();
        logic [31:0] d;
        wr(w0(7), 32'hE00);
        check("R6 alt function no oe", 64'(pad_oe[7]), 0);
        check("R6 mode exported", 64'(pad_mode[28 +: 4]), 3);
        wr(w0(7), 32'hE01);
        rd(w0(7), d); check("R6 bit0 ignored", 64'(d), 64'hE00);
        check("R6 no drive", 64'(pad_out[7]), 0);
        wr(w0(7), 32'h201);
        rd(w0(7), d); check("R6 guard uses held mode", 64'(d), 64'h200);
        wr(w0(7), 32'h201);
        rd(w0(7), d); check("R6 bit0 after return", 64'(d), 64'h201);
        check("R6 drives again", 64'(pad_out[7]), 1);
    endtask

    task automatic t_owner();
        logic [31:0] d;
        wr('h024, 32'h10);
        rd('h024, d); check("R7 owner readback", 64'(d), 64'h10);
        rd('h020, d); check("R7 other owner word", 64'(d), 0);
        wr(w0(10), 32'h201);
        rd(w0(10), d); check("R7 bit0 blocked", 64'(d), 64'h200);
        check("R7 pad not high", 64'(pad_out[10]), 0);
        wr('h024, 32'h0);
        wr(w0(10), 32'h201);
        rd(w0(10), d); check("R7 bit0 after release", 64'(d), 64'h201);
        check("R7 pad drives", 64'(pad_out[10]), 1);
    endtask

    task automatic t_term();
        logic [31:0] d;
        wr(w1(2), 32'hFFFF_FFFF);
        rd(w1(2), d); check("R8 word1 mask", 64'(d), 64'h3_FF00);
        check("R8 term all ones", 64'(pad_term[8 +: 4]), 64'hF);
        wr(w1(2), 32'h1000);
        check("R8 pull-down code", 64'(pad_term[8 +: 4]), 4);
        wr(w1(2), 32'h3000);
        check("R8 pull-up code", 64'(pad_term[8 +: 4]), 64'hC);
        check("R8 other pads none", 64'(pad_term & ~(64'hF << 8)), 0);
    endtask

    task automatic t_holes();
        logic [31:0] d;
        wr('h040, 32'hFFFF);
        rd('h040, d); check("R9 hole read", 64'(d), 0);
        rd(w0(3) + 2, d); check("R9 misaligned read", 64'(d), 0);
        wr(w0(12) + 1, 32'h201);
        rd(w0(12), d); check("R9 misaligned write dropped", 64'(d), 64'h100);
        rd('h028, d); check("R9 owner word beyond pads", 64'(d), 0);
        rd(PBASE + 8*NPADS, d); check("R9 past last pad", 64'(d), 0);
    endtask

    task automatic t_rdata_hold();
        logic [31:0] d;
        rd('h010, d);
        repeat (4) @(negedge clk);
        check("R10 rdata holds", 64'(bus_rdata), 64'hA5A5_0003);
        wr('h010, 32'h0);
        check("R10 rdata unaffected by write", 64'(bus_rdata), 64'hA5A5_0003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_base_misc();
        t_output();
        t_input();
        t_mode();
        t_owner();
        t_term();
        t_holes();
        t_rdata_hold();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule